// File: doc/BRIEF.md
# Serial-Loaded Addressed Register Bank

This block receives configuration words over a write-only three-wire serial port: a serial clock, a serial data line and an active-low chip select. It loads each word into one of thirteen 14-bit configuration registers and drives all thirteen values as parallel outputs. A word has 18 bits, sent most significant bit first. The upper 14 bits carry the register value and the lowest 4 bits carry the register address. When chip select rises, the word now in the shift register is committed.

The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the serial clock edges are detected in the system-clock domain, so every register update is synchronous to `clk`. The shift register never counts clocks and only keeps the most recent 18 bits. A short frame therefore takes its upper data bits from earlier frames, which lets a host update only the low-order bits of a register with a few clocks.

A two-state framing machine drives the commit. In `FS_IDLE`, chip select is seen high. The transition FRAME_START is taken when the synchronized chip select reads low and leads to `FS_FRAME`. In `FS_FRAME`, the transition FRAME_END is taken when chip select reads high again. That transition returns to `FS_IDLE` and raises the commit. A commit to an address of 13 or above is dropped. Every accepted commit updates one register and gives a one-cycle update strobe together with the address.

Top module: `cfg_shift_bank`

## Requirements
- R1: On asynchronous reset, registers 0..12 hold these 14-bit values (hex): 1140, 00CA, 1007, 30A2, 1DDD, 1824, 1C00, 002A, 0025, 0200, 03C0, 007F, 0000. Register i appears on `regs_o[14*i +: 14]`.
- R2: A word is 18 bits and is shifted in most significant bit first. Word bits 17..4 are the register value and word bits 3..0 are the register address.
- R3: A bit is captured only on a rising edge of `sclk_i` while `csn_i` is low. Serial clock edges while `csn_i` is high leave the shift register unchanged.
- R4: A rising edge of `csn_i` writes the 14 data bits of the shift register to the register named by its 4 address bits. All other registers keep their values.
- R5: The shift register keeps only the last 18 bits captured. In a frame longer than 18 clocks, the earliest bits are discarded.
- R6: A frame shorter than 18 clocks is accepted as it is. Its upper data bits are the bits left in the shift register from earlier frames.
- R7: A commit whose address is 13, 14 or 15 changes no register and gives no update strobe.
- R8: Each accepted commit raises `upd_strobe_o` for exactly one `clk` cycle, with `upd_addr_o` holding the address. The strobe and the new register value change together, at the third rising `clk` edge after the edge that first samples `csn_i` high.
- R9: The shift register is cleared to zero only by the asynchronous reset. A chip select falling edge does not clear it, and neither does the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| csn_i | input | 1 | Active-low chip select, asynchronous |
| regs_o | output | 182 | All 13 registers, register i at bits 14*i+13..14*i |
| upd_strobe_o | output | 1 | One-cycle pulse on each accepted commit |
| upd_addr_o | output | 4 | Address of the register just committed |

## Verification
Properties check on every cycle that the commit pulse lasts one cycle and comes only as the machine leaves `FS_FRAME`. They also check that no out-of-range address ever reaches the bank, and that the registers never change while the update strobe is low. Whether the committed value is the right one can only be shown by the bench's scenarios. These include the bit order, the discarded bits of an overlong frame, the leftover bits reused by a short frame, the ignored clocks while chip select is high and the zero left by reset. A behavioural model in the bench tracks the expected outputs on every clock.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int CB_DATA_W   = 14;
    localparam int CB_ADDR_W   = 4;
    localparam int CB_NUM_REGS = 13;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_FRAME = 1'b1
    } frame_state_t;

    function automatic logic [CB_DATA_W-1:0] reg_default(input int idx);
        logic [CB_DATA_W-1:0] v;
        unique case (idx)
            0:       v = 14'h1140;
            1:       v = 14'h00CA;
            2:       v = 14'h1007;
            3:       v = 14'h30A2;
            4:       v = 14'h1DDD;
            5:       v = 14'h1824;
            6:       v = 14'h1C00;
            7:       v = 14'h002A;
            8:       v = 14'h0025;
            9:       v = 14'h0200;
            10:      v = 14'h03C0;
            11:      v = 14'h007F;
            default: v = 14'h0000;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/cfgbank_sync.sv
module cfgbank_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgbank_frame.sv
module cfgbank_frame
    import cfgbank_pkg::*;
#(
    parameter int DATA_W   = CB_DATA_W,
    parameter int ADDR_W   = CB_ADDR_W,
    parameter int NUM_REGS = CB_NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              csn_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int              WORD_W = DATA_W + ADDR_W;
    localparam logic [ADDR_W:0] NREG   = NUM_REGS[ADDR_W:0];

    frame_state_t      state_q, state_d;
    logic              sclk_d;
    logic [WORD_W-1:0] shift_q;
    logic              bit_take;
    logic              commit;
    logic              addr_ok;

    assign bit_take = sclk_s && !sclk_d && !csn_s;
    assign addr_ok  = {1'b0, shift_q[ADDR_W-1:0]} < NREG;

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (!csn_s) state_d = FS_FRAME;
            end
            FS_FRAME: begin
                if (csn_s) begin
                    state_d = FS_IDLE;
                    commit  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            shift_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (bit_take) shift_q <= {shift_q[WORD_W-2:0], sdata_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= commit && addr_ok;
            wr_addr <= shift_q[ADDR_W-1:0];
            wr_data <= shift_q[WORD_W-1:ADDR_W];
        end
    end

    a_r8_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r4_commit_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state_q) == FS_FRAME && state_q == FS_IDLE));

    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < NREG));

    a_r3_shift_holds_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> $stable(shift_q));
endmodule

// File: rtl/cfg_shift_bank.sv
module cfg_shift_bank
    import cfgbank_pkg::*;
#(
    parameter int DATA_W      = CB_DATA_W,
    parameter int ADDR_W      = CB_ADDR_W,
    parameter int NUM_REGS    = CB_NUM_REGS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sclk_i,
    input  logic                         sdata_i,
    input  logic                         csn_i,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o,
    output logic                         upd_strobe_o,
    output logic [ADDR_W-1:0]            upd_addr_o
);
    logic              sclk_s, sdata_s, csn_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [NUM_REGS*DATA_W-1:0] bank_q;

    cfgbank_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
    cfgbank_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sdata (
        .clk(clk), .rst_n(rst_n), .d_i(sdata_i), .q_o(sdata_s));
    cfgbank_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst_n(rst_n), .d_i(csn_i), .q_o(csn_s));

    cfgbank_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sclk_s), .sdata_s(sdata_s), .csn_s(csn_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[i*DATA_W +: DATA_W] <= reg_default(i);
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                bank_q[i*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_strobe_o <= 1'b0;
            upd_addr_o   <= '0;
        end else begin
            upd_strobe_o <= wr_en;
            if (wr_en) upd_addr_o <= wr_addr;
        end
    end

    assign regs_o = bank_q;

    a_r4_bank_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe_o |-> $stable(bank_q));

    a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe_o |=> !upd_strobe_o);
endmodule

// File: tb/cfg_shift_bank_test.sv
module cfg_shift_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 14;
    localparam int NR = 13;
    localparam int FLAT = DW * NR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
    logic [FLAT-1:0] regs;
    logic strobe;
    logic [3:0] saddr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    cfg_shift_bank uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sck), .sdata_i(sdi), .csn_i(csn),
        .regs_o(regs), .upd_strobe_o(strobe), .upd_addr_o(saddr));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [13:0] dflt(input int i);
        logic [13:0] t [13] = '{14'h1140, 14'h00CA, 14'h1007, 14'h30A2, 14'h1DDD,
                                14'h1824, 14'h1C00, 14'h002A, 14'h0025, 14'h0200,
                                14'h03C0, 14'h007F, 14'h0000};
        return t[i];
    endfunction

    task automatic chk(input string req, input logic [FLAT-1:0] act, input logic [FLAT-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural reference model, three-cycle output lag kept in queues
    logic [17:0] m_shift;
    logic [13:0] m_bank [NR];
    logic m_sck_p, m_csn_p;
    logic [FLAT-1:0] q_bank [$];
    logic q_stb [$];
    logic [3:0] q_adr [$];
    logic [3:0] m_adr;

    always @(posedge clk) begin
        logic stb;
        logic [FLAT-1:0] flat;
        stb = 1'b0;
        if (!rst_n) begin
            m_shift = '0;
            for (int i = 0; i < NR; i++) m_bank[i] = dflt(i);
            m_sck_p = 1'b0; m_csn_p = 1'b1; m_adr = '0;
        end else begin
            if (csn && !m_csn_p) begin
                if (m_shift[3:0] < 4'd13) begin
                    m_bank[m_shift[3:0]] = m_shift[17:4];
                    stb = 1'b1;
                    m_adr = m_shift[3:0];
                end
            end
            if (sck && !m_sck_p && !csn) m_shift = {m_shift[16:0], sdi};
            m_sck_p = sck; m_csn_p = csn;
        end
        for (int i = 0; i < NR; i++) flat[i*DW +: DW] = m_bank[i];
        q_bank.push_back(flat); q_stb.push_back(stb); q_adr.push_back(m_adr);
        if (q_bank.size() > 4) begin
            void'(q_bank.pop_front()); void'(q_stb.pop_front()); void'(q_adr.pop_front());
        end
    end

    // per-clock comparison and strobe monitor
    int stb_count = 0;
    logic [3:0] stb_last = '0;
    always @(negedge clk) begin
        if (rst_n && q_bank.size() == 4) begin
            chk("R4 per-clock bank", regs, q_bank[0]);
            chk("R8 per-clock strobe", FLAT'(strobe), FLAT'(q_stb[0]));
            if (q_stb[0]) chk("R8 per-clock addr", FLAT'(saddr), FLAT'(q_adr[0]));
        end
        if (rst_n && strobe) begin
            stb_count++;
            stb_last = saddr;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] w, input int nbits);
        csn = 1'b0; cyc(3);
        for (int b = nbits - 1; b >= 0; b--) begin
            sdi = w[b]; cyc(2);
            sck = 1'b1; cyc(3);
            sck = 1'b0; cyc(1);
        end
        csn = 1'b1; cyc(10);
    endtask

    function automatic logic [13:0] rg(input int i);
        return regs[i*DW +: DW];
    endfunction

    initial begin
        logic [FLAT-1:0] snap;
        int sc;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        for (int i = 0; i < NR; i++) chk($sformatf("R1 default reg%0d", i), FLAT'(rg(i)), FLAT'(dflt(i)));

        frame({28'd0, 4'd5}, 4);
        chk("R9 zero shift after reset", FLAT'(rg(5)), '0);
        chk("R8 strobe count", FLAT'(stb_count), FLAT'(1));
        chk("R8 strobe addr", FLAT'(stb_last), FLAT'(5));

        frame({14'd0, 14'h2ABC, 4'd3}, 18);
        chk("R2 full word to reg3", FLAT'(rg(3)), FLAT'(14'h2ABC));
        chk("R4 neighbour reg2 kept", FLAT'(rg(2)), FLAT'(dflt(2)));

        sdi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sck = 1'b1; cyc(3); sck = 1'b0; cyc(3);
        end
        frame({28'd0, 4'd1}, 4);
        chk("R6 R3 short frame reuses bits", FLAT'(rg(1)), FLAT'(14'h2BC3));

        frame({10'd0, 4'hF, 14'h0155, 4'd7}, 22);
        chk("R5 long frame keeps last 18", FLAT'(rg(7)), FLAT'(14'h0155));

        snap = regs; sc = stb_count;
        frame({14'd0, 14'h3FFF, 4'd13}, 18);
        chk("R7 addr 13 no change", regs, snap);
        chk("R7 addr 13 no strobe", FLAT'(stb_count), FLAT'(sc));

        frame({14'd0, 14'h1234, 4'd12}, 18);
        chk("R4 top address reg12", FLAT'(rg(12)), FLAT'(14'h1234));
        chk("R8 strobe addr 12", FLAT'(stb_last), FLAT'(12));
        chk("R8 strobe count total", FLAT'(stb_count), FLAT'(sc + 1));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule